// File: doc/BRIEF.md
# Trainable Adaptive Logic Node

This block is one two-input node of a binary tree of adaptive logic. It receives a left and a right child value and drives one output bit. The node computes one of four functions: AND, OR, pass-left or pass-right. Two saturating counters hold the node's state, and the counters select the function. One counter belongs to the input pattern left=0/right=1. The other counter belongs to the pattern left=1/right=0. When the two inputs are equal, the output is that common value. When they differ, the output is the most significant bit of the counter for that pattern.

During training, the tree controller pulses `train_en` for one cycle. The node then looks at its responsibility input and the desired output `target`. If the node is responsible and its inputs differ, it moves the matching counter one step toward `target`. At all times the node computes combinationally whether each of its children is responsible. Those two bits feed the children's responsibility inputs for the next layer's pulse. A node built as a tree root treats its responsibility as always true.

For load and inspection, `scan_en` turns the two counters into one serial shift segment. Segments of several nodes chain through `scan_in` and `scan_out`.

Top module: `aln_node`

## Requirements
- R1: The output is the common value when `left_in == right_in`. For (left=0,right=1) the output is bit CW-1 of the low-pattern counter C01. For (left=1,right=0) it is bit CW-1 of the high-pattern counter C10. The MSB pair {C10,C01} = 00 means AND, 11 means OR, 10 means LEFT and 01 means RIGHT.
- R2: The counter width CW defaults to 6. Reset loads both counters with 2^(CW-1)-1, so after reset the node computes AND and outputs 0 for both unequal patterns.
- R3: Learning is enabled when `train_en`=1, the node is responsible, `scan_en`=0 and the inputs differ. At such a clock edge, the counter of the current pattern moves by exactly one: +1 if `target`=1 and -1 if `target`=0. The other counter keeps its value.
- R4: A counter at all-ones does not move further up. A counter at zero does not move further down.
- R5: Neither counter changes when `train_en`=0, when the node is not responsible, or when the inputs are equal.
- R6: `resp_left` is 1 only when the node is responsible and one of these holds: the function is OR and `right_in`=0, the function is AND and `right_in`=1, or the function is LEFT. `resp_right` mirrors this with `left_in` and RIGHT. Both are 0 when the node is not responsible.
- R7: With parameter IS_ROOT=1, the node behaves as if `resp_in` were always 1, for both learning and child responsibility.
- R8: While `scan_en`=1, each clock edge shifts the 2·CW-bit word {C01,C10} one place toward its LSB. `scan_in` enters C01 bit CW-1. `scan_out` always shows C10 bit 0. A word shifted in LSB first over 2·CW cycles lands with bit i at word position i.
- R9: When `scan_en`=1, the scan shift takes place and training does not occur, even if `train_en` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| left_in | input | 1 | Left child value |
| right_in | input | 1 | Right child value |
| target | input | 1 | Desired output during training |
| resp_in | input | 1 | Responsibility from parent (ignored when IS_ROOT=1) |
| train_en | input | 1 | One-cycle learning pulse |
| scan_en | input | 1 | Selects serial shift of the counters |
| scan_in | input | 1 | Serial data into the counter segment |
| node_out | output | 1 | Node function result |
| resp_left | output | 1 | Responsibility for the left child |
| resp_right | output | 1 | Responsibility for the right child |
| scan_out | output | 1 | Serial data out of the counter segment |

## Verification
The hardest states to reach from the ports are the counter limits. Random training drifts only slowly away from the reset value, so it rarely drives a 6-bit counter into saturation. The bench therefore shifts in all-ones and zero values through the scan path. It then applies learning pulses that push the counters past those limits, and reads the state back serially. The random phase then biases `target` to ones for long stretches and to zeros for others, so the counters walk toward both ends. Scan and training pulses are also made to collide in the random phase.

// File: rtl/aln_node.sv
module aln_node #(
  parameter int CW      = 6,
  parameter bit IS_ROOT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic left_in,
  input  logic right_in,
  input  logic target,
  input  logic resp_in,
  input  logic train_en,
  input  logic scan_en,
  input  logic scan_in,
  output logic node_out,
  output logic resp_left,
  output logic resp_right,
  output logic scan_out
);

  localparam int MSB = CW - 1;
  localparam logic [CW-1:0] INIT = {1'b0, {(CW-1){1'b1}}};
  localparam logic [CW-1:0] TOP  = {CW{1'b1}};
  localparam logic [CW-1:0] BOT  = '0;
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] c01, c10;
  logic resp, learn, is_and, is_or, is_left, is_right;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input logic up);
    if (up) return (c == TOP) ? c : c + ONE;
    else    return (c == BOT) ? c : c - ONE;
  endfunction

  assign resp     = IS_ROOT | resp_in;
  assign learn    = train_en & resp & (left_in ^ right_in) & ~scan_en;

  assign is_and   = ~c10[MSB] & ~c01[MSB];
  assign is_or    =  c10[MSB] &  c01[MSB];
  assign is_left  =  c10[MSB] & ~c01[MSB];
  assign is_right = ~c10[MSB] &  c01[MSB];

  always_comb begin
    unique case ({left_in, right_in})
      2'b01:   node_out = c01[MSB];
      2'b10:   node_out = c10[MSB];
      default: node_out = left_in;
    endcase
  end

  assign resp_left  = resp & ((is_or & ~right_in) | (is_and & right_in) | is_left);
  assign resp_right = resp & ((is_or & ~left_in)  | (is_and & left_in)  | is_right);
  assign scan_out   = c10[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c01 <= INIT;
      c10 <= INIT;
    end else if (scan_en) begin
      c01 <= {scan_in, c01[CW-1:1]};
      c10 <= {c01[0], c10[CW-1:1]};
    end else if (learn) begin
      if (right_in) c01 <= step(c01, target);
      else          c10 <= step(c10, target);
    end
  end

endmodule

// File: rtl/aln_node_chk.sv
module aln_node_chk #(
  parameter int CW      = 6,
  parameter bit IS_ROOT = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          left_in,
  input logic          right_in,
  input logic          target,
  input logic          resp_in,
  input logic          train_en,
  input logic          scan_en,
  input logic          scan_in,
  input logic          node_out,
  input logic          resp_left,
  input logic          resp_right,
  input logic [CW-1:0] c01,
  input logic [CW-1:0] c10
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  assert_eval_equal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (left_in == right_in) |-> (node_out == left_in));

  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && train_en && (IS_ROOT || resp_in) && !left_in && right_in && target && (c01 != '1))
    |=> (c01 == $past(c01) + ONE) && $stable(c10));

  assert_sat_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && train_en && (IS_ROOT || resp_in) && !left_in && right_in && target && (c01 == '1))
    |=> (c01 == '1));

  assert_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && train_en && (IS_ROOT || resp_in) && left_in && !right_in && !target && (c10 == '0))
    |=> (c10 == '0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !(train_en && (IS_ROOT || resp_in) && (left_in != right_in)))
    |=> ($stable(c01) && $stable(c10)));

  assert_child_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_ROOT && !resp_in) |-> (!resp_left && !resp_right));

  assert_scan_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (c01[CW-1] == $past(scan_in)) && (c10[CW-1] == $past(c01[0])));

  assert_scan_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && train_en) |=> (c01[CW-2:0] == $past(c01[CW-1:1])) && (c10[CW-2:0] == $past(c10[CW-1:1])));

endmodule

bind aln_node aln_node_chk #(.CW(CW), .IS_ROOT(IS_ROOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .left_in(left_in), .right_in(right_in),
  .target(target), .resp_in(resp_in), .train_en(train_en), .scan_en(scan_en),
  .scan_in(scan_in), .node_out(node_out), .resp_left(resp_left),
  .resp_right(resp_right), .c01(c01), .c10(c10)
);

// File: tb/sim_aln_node.sv
module sim_aln_node;
  localparam int PERIOD = 10;
  localparam int CW = 6;
  localparam int W2 = 2 * CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic l = 0, r = 0, tgt = 0, rin = 0, ten = 0, sen = 0, sin0 = 0, sin1 = 0;
  logic o0, rl0, rr0, so0, o1, rl1, rr1, so1;
  logic [CW-1:0] m01 [2];
  logic [CW-1:0] m10 [2];
  int nchk = 0, nerr = 0;

  always #(PERIOD/2) clk = ~clk;

  aln_node #(.CW(CW), .IS_ROOT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .left_in(l), .right_in(r), .target(tgt),
    .resp_in(rin), .train_en(ten), .scan_en(sen), .scan_in(sin0),
    .node_out(o0), .resp_left(rl0), .resp_right(rr0), .scan_out(so0));

  aln_node #(.CW(CW), .IS_ROOT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .left_in(l), .right_in(r), .target(tgt),
    .resp_in(rin), .train_en(ten), .scan_en(sen), .scan_in(sin1),
    .node_out(o1), .resp_left(rl1), .resp_right(rr1), .scan_out(so1));

  function automatic logic f_out(input logic [CW-1:0] a, input logic [CW-1:0] b, input logic x, input logic y);
    if (x == y) return x;
    return x ? b[CW-1] : a[CW-1];
  endfunction

  function automatic logic f_child(input logic [CW-1:0] a, input logic [CW-1:0] b, input logic rs,
                                   input logic other, input logic pass_me);
    logic fand, f_or;
    fand = !a[CW-1] && !b[CW-1];
    f_or = a[CW-1] && b[CW-1];
    return rs && ((f_or && !other) || (fand && other) || pass_me);
  endfunction

  function automatic logic [CW-1:0] f_step(input logic [CW-1:0] c, input logic up);
    if (up) return (c == {CW{1'b1}}) ? c : c + 1'b1;
    return (c == '0) ? c : c - 1'b1;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic mupd(input int i);
    logic rs, si;
    logic [W2-1:0] w;
    rs = (i == 1) || rin;
    si = (i == 1) ? sin1 : sin0;
    if (sen) begin
      w = {si, m01[i], m10[i][CW-1:1]};
      m01[i] = w[W2-1:CW];
      m10[i] = w[CW-1:0];
    end else if (ten && rs && (l != r)) begin
      if (!l) m01[i] = f_step(m01[i], tgt);
      else    m10[i] = f_step(m10[i], tgt);
    end
  endtask

  task automatic cycle();
    #1;
    chk("R1 node_out", o0, f_out(m01[0], m10[0], l, r));
    chk("R1 root node_out", o1, f_out(m01[1], m10[1], l, r));
    chk("R6 resp_left", rl0, f_child(m01[0], m10[0], rin, r, m10[0][CW-1] && !m01[0][CW-1]));
    chk("R6 resp_right", rr0, f_child(m01[0], m10[0], rin, l, m01[0][CW-1] && !m10[0][CW-1]));
    chk("R7 root resp_left", rl1, f_child(m01[1], m10[1], 1'b1, r, m10[1][CW-1] && !m01[1][CW-1]));
    chk("R7 root resp_right", rr1, f_child(m01[1], m10[1], 1'b1, l, m01[1][CW-1] && !m10[1][CW-1]));
    chk("R8 scan_out", so0, m10[0][0]);
    chk("R8 root scan_out", so1, m10[1][0]);
    @(posedge clk);
    mupd(0);
    mupd(1);
    @(negedge clk);
  endtask

  task automatic readback(input string tag);
    for (int k = 0; k < W2; k++) begin
      sen = 1; ten = $urandom % 2; tgt = $urandom % 2; rin = 1;
      l = $urandom % 2; r = $urandom % 2;
      sin0 = so0; sin1 = so1;
      #1;
      chk(tag, so0, m10[0][0]);
      cycle();
    end
    sen = 0; ten = 0;
  endtask

  task automatic load0(input logic [W2-1:0] v);
    for (int k = 0; k < W2; k++) begin
      sen = 1; ten = 0; sin0 = v[k]; sin1 = so1;
      cycle();
    end
    sen = 0;
  endtask

  task automatic train(input logic x, input logic y, input logic t, input logic rs);
    sen = 0; ten = 1; l = x; r = y; tgt = t; rin = rs;
    cycle();
    ten = 0;
  endtask

  task automatic probe(input string tag, input logic x, input logic y, input logic exp);
    sen = 0; ten = 0; l = x; r = y;
    #1;
    chk(tag, o0, exp);
    cycle();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_a1a1));
    for (int i = 0; i < 2; i++) begin
      m01[i] = {1'b0, {(CW-1){1'b1}}};
      m10[i] = {1'b0, {(CW-1){1'b1}}};
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2: reset state is AND, counters at 31
    probe("R2 reset (0,1)", 1'b0, 1'b1, 1'b0);
    probe("R2 reset (1,0)", 1'b1, 1'b0, 1'b0);
    readback("R2 reset readback");

    // R3: single steps across the threshold
    train(1'b0, 1'b1, 1'b1, 1'b1);
    probe("R3 c01 up to 32", 1'b0, 1'b1, 1'b1);
    probe("R3 c10 untouched", 1'b1, 1'b0, 1'b0);
    train(1'b0, 1'b1, 1'b0, 1'b1);
    probe("R3 c01 down to 31", 1'b0, 1'b1, 1'b0);
    train(1'b1, 1'b0, 1'b1, 1'b1);
    probe("R3 c10 up to 32", 1'b1, 1'b0, 1'b1);
    readback("R3 readback");

    // R4: saturation at both ends
    load0({6'h3f, 6'h00});
    repeat (3) train(1'b0, 1'b1, 1'b1, 1'b1);
    repeat (3) train(1'b1, 1'b0, 1'b0, 1'b1);
    probe("R4 c01 held at max", 1'b0, 1'b1, 1'b1);
    probe("R4 c10 held at zero", 1'b1, 1'b0, 1'b0);
    readback("R4 saturation readback");
    train(1'b0, 1'b1, 1'b0, 1'b1);
    readback("R4 leave max");

    // R5: no change when not responsible, inputs equal, or no pulse
    load0({6'h20, 6'h1f});
    train(1'b0, 1'b1, 1'b0, 1'b0);
    train(1'b1, 1'b0, 1'b1, 1'b0);
    probe("R5 unresponsible (0,1)", 1'b0, 1'b1, 1'b1);
    probe("R5 unresponsible (1,0)", 1'b1, 1'b0, 1'b0);
    train(1'b1, 1'b1, 1'b0, 1'b1);
    train(1'b0, 1'b0, 1'b1, 1'b1);
    sen = 0; ten = 0; l = 0; r = 1; tgt = 0; rin = 1; cycle();
    readback("R5 hold readback");

    // R9: scan and train together
    load0({6'h15, 6'h2a});
    sen = 1; ten = 1; rin = 1; l = 0; r = 1; tgt = 1; sin0 = 1; sin1 = 0;
    cycle();
    sen = 0; ten = 0;
    readback("R9 scan priority readback");

    // random phase, target biased per phase
    for (int k = 0; k < 3000; k++) begin
      l = $urandom % 2; r = $urandom % 2;
      rin = ($urandom % 4) != 0;
      ten = $urandom % 2;
      sen = ($urandom % 16) == 0;
      sin0 = $urandom % 2; sin1 = $urandom % 2;
      if (((k / 500) % 2) == 0) tgt = ($urandom % 8) != 0;
      else                      tgt = ($urandom % 8) == 0;
      cycle();
      if ((k % 250) == 249) readback("R3 R4 R5 random readback");
    end

    finish_run();
  end
endmodule